// File: doc/BRIEF.md
# Two-Street Crossing Light Sequencer

This block is a Moore state machine that runs the lights at a crossing of two streets, called street A and street B. Each street has a presence sensor input that is high while vehicles wait or flow on it. The machine keeps one street green for as long as that street's sensor shows traffic. When the sensor drops, that street turns yellow for one clock. The other street then turns green.

State is held in a 2-bit register that loads on the rising clock edge. A combinational next-state function reads the current state and the sensors. A separate decode maps the current state alone onto two 2-bit light codes, one per street. The sensors are taken to be already synchronous to the clock.

Top module: `xing_lights`

## Requirements
- R1: A synchronous active-high reset puts the state at 00. Street A is then green (code 00) and street B red (code 10) on the cycle after reset.
- R2: Light codes are green = 00, yellow = 01 and red = 10. Code 11 never appears on either output.
- R3: In state 00 (A green, B red) the machine holds while `sens_a`=1 and goes to 01 when `sens_a`=0. `sens_b` has no effect in this state.
- R4: State 01 (A yellow, B red) always goes to 10 at the next edge, whatever the sensors read.
- R5: In state 10 (A red, B green) the machine holds while `sens_b`=1 and goes to 11 when `sens_b`=0. `sens_a` has no effect in this state.
- R6: State 11 (A red, B yellow) always goes to 00 at the next edge.
- R7: In every cycle at least one street shows red. The other street shows exactly one of green, yellow or red.
- R8: The light codes depend on the registered state only. A sensor change between edges does not alter the lights until the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| sens_a | input | 1 | Traffic present on street A |
| sens_b | input | 1 | Traffic present on street B |
| lamp_a | output | 2 | Light code for street A |
| lamp_b | output | 2 | Light code for street B |

## Verification
A behavioural model in the bench tracks which street owns the green and compares both light codes at every clock.

The stimulus includes held-high sensor runs, which show that green is kept while traffic stays present. Single-cycle drops show that yellow lasts one clock. Sensor values driven during yellow show that yellow ignores the sensors. The idle street's sensor is toggled during each green, which shows that input is ignored.

A sensor is also changed in the middle of a cycle, which shows the lights move only at edges. A long pseudo-random stretch covers mixed patterns, and the one-red-at-least rule is checked in every cycle.

// File: rtl/xing_lights.sv
module xing_lights (
  input  logic       clk,
  input  logic       rst,
  input  logic       sens_a,
  input  logic       sens_b,
  output logic [1:0] lamp_a,
  output logic [1:0] lamp_b
);
  logic [1:0] st, st_nx;

  assign st_nx[1] = st[1] ^ st[0];
  assign st_nx[0] = (~st[1] & ~st[0] & ~sens_a) | (st[1] & ~st[0] & ~sens_b);

  always_ff @(posedge clk) begin
    if (rst) st <= 2'b00;
    else     st <= st_nx;
  end

  assign lamp_a = {st[1], ~st[1] & st[0]};
  assign lamp_b = {~st[1], st[1] & st[0]};

  AST_RESET_STATE: assert property (@(posedge clk) $past(rst) |-> (lamp_a == 2'b00 && lamp_b == 2'b10)); // R1
  AST_NO_CODE11: assert property (@(posedge clk) disable iff (rst) (lamp_a != 2'b11 && lamp_b != 2'b11)); // R2
  AST_A_GREEN: assert property (@(posedge clk) disable iff (rst) (lamp_a == 2'b00 && !sens_a) |=> lamp_a == 2'b01); // R3
  AST_A_YELLOW: assert property (@(posedge clk) disable iff (rst) lamp_a == 2'b01 |=> lamp_b == 2'b00); // R4
  AST_B_GREEN: assert property (@(posedge clk) disable iff (rst) (lamp_b == 2'b00 && !sens_b) |=> lamp_b == 2'b01); // R5
  AST_B_YELLOW: assert property (@(posedge clk) disable iff (rst) lamp_b == 2'b01 |=> lamp_a == 2'b00); // R6
  AST_ONE_RED: assert property (@(posedge clk) disable iff (rst) (lamp_a == 2'b10 || lamp_b == 2'b10)); // R7
endmodule

// File: tb/sim_xing_lights.sv
module sim_xing_lights;
  logic clk = 0, rst = 1, sens_a = 0, sens_b = 0;
  logic [1:0] lamp_a, lamp_b;
  int n_run = 0, n_fail = 0, cyc = 0;
  int phase = 0;
  int seed = 7;

  xing_lights u0 (.clk(clk), .rst(rst), .sens_a(sens_a), .sens_b(sens_b),
                  .lamp_a(lamp_a), .lamp_b(lamp_b));

  always #2.5 clk = ~clk;

  function automatic logic [1:0] exp_a(int p);
    return p == 0 ? 2'b00 : (p == 1 ? 2'b01 : 2'b10);
  endfunction
  function automatic logic [1:0] exp_b(int p);
    return p == 2 ? 2'b00 : (p == 3 ? 2'b01 : 2'b10);
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] ex);
    n_run++;
    if (act !== ex) begin
      n_fail++;
      $display("FAIL %s cyc=%0d act=%b exp=%b", tag, cyc, act, ex);
    end
  endtask

  // model: advance phase at each edge using sensors seen before the edge
  task automatic step(logic a, logic b);
    sens_a = a; sens_b = b;
    @(posedge clk);
    if (rst) phase = 0;
    else case (phase)
      0: phase = a ? 0 : 1;
      1: phase = 2;
      2: phase = b ? 2 : 3;
      default: phase = 0;
    endcase
    cyc++;
    #1;
    chk("R3/R4/R5/R6 lampA", lamp_a, exp_a(phase));
    chk("R3/R4/R5/R6 lampB", lamp_b, exp_b(phase));
    n_run++;
    if (lamp_a == 2'b11 || lamp_b == 2'b11) begin
      n_fail++; $display("FAIL R2 code11 a=%b b=%b exp=not 11", lamp_a, lamp_b);
    end
    n_run++;
    if (lamp_a != 2'b10 && lamp_b != 2'b10) begin
      n_fail++; $display("FAIL R7 no red a=%b b=%b exp=one 10", lamp_a, lamp_b);
    end
  endtask

  initial begin
    #300000;
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1;
    step(0, 0); step(1, 1);
    rst = 0;
    chk("R1 reset A", lamp_a, 2'b00);
    chk("R1 reset B", lamp_b, 2'b10);
    // R3: hold A green with B toggling
    for (int i = 0; i < 6; i++) step(1, i[0]);
    // drop A -> yellow; R4: yellow with sensors high
    step(0, 1); step(1, 1);
    // R5: hold B green with A toggling
    for (int i = 0; i < 6; i++) step(i[0], 1);
    step(1, 0); step(0, 1); // R6
    // R8: change sensor mid cycle, lights stable until edge
    step(1, 0);
    sens_a = 0; #1;
    chk("R8 midcycle A", lamp_a, exp_a(phase));
    chk("R8 midcycle B", lamp_b, exp_b(phase));
    // all-zero sensors: continuous cycling
    for (int i = 0; i < 12; i++) step(0, 0);
    // random stretch
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom(seed + i) % 4;
      step(r[0], r[1]);
    end
    // mid-run reset R1
    rst = 1; step(1, 0); rst = 0;
    chk("R1 rerst A", lamp_a, 2'b00);
    chk("R1 rerst B", lamp_b, 2'b10);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule